// File: doc/BRIEF.md
# Processor Memory-Map Decoder with Guarded Calibration RAM

This block sits between a 16-bit address processor and its memories. From the address bus, qualified by the valid-address strobe and the phase-2 clock, it produces one chip select per device: program ROM, scratch RAM, a battery-backed calibration RAM and a slow peripheral I/O window. It also produces a single write strobe. Decoding is partial, so every device answers at mirrored addresses. Where two mirrors overlap, a fixed priority picks exactly one device.

The calibration RAM has two guards. It accepts writes only when the calibration-mode input is high, or when the access falls inside its zero-storage sub-area. In any other case the select still asserts, so a read proceeds, but no write strobe is issued. In addition, its select is forced off while the supply-low input is high and for a parameterised number of cycles after that input clears. This shields its contents during supply transitions.

All outputs are registered. Each select and the strobe appear one clock after the inputs that cause them.

Top module: `memmap_decode`

## Requirements
- R1: `rom_cs` asserts for a qualified access when address bits 15, 13 and 12 are all 1. Bit 14 is ignored, so both F000–FFFF and B000–BFFF select the ROM.
- R2: `sram_cs` asserts for a qualified access when address bits 15 down to 10 are all 0. Bits 9 and 8 are ignored, so 0000–00FF is mirrored at 0100, 0200 and 0300.
- R3: `nvram_cs` asserts for a qualified access when bit 15 is 1, bit 14 is 0 and bit 12 is 1, provided the ROM does not claim the address. In effect it answers at 9000–9FFF.
- R4: `io_cs` asserts for a qualified access when bits 15, 14 and 11 are all 1, provided the ROM does not claim the address (for example at C800 or E800).
- R5: The priority order is ROM, then I/O, then calibration RAM, then scratch RAM. At most one select is high in any cycle, so F800 selects the ROM and B000 selects the ROM.
- R6: No select and no write strobe is produced unless both `vma` and `phi2` are 1.
- R7: `wr_stb` asserts only when all of the following hold: `rw` is 0 (write), `wr_timing` is 1, and the target is the scratch RAM, the I/O window or a permitted calibration-RAM location. It never asserts for a ROM address or for an unmapped address.
- R8: A calibration-RAM write is permitted only when `cal_mode` is 1 or address bits 7 and 6 are both 1 (zero area). A blocked write still asserts `nvram_cs` but gives no `wr_stb`.
- R9: `nvram_cs` stays low while `supply_low` is 1. After the last clock edge that samples `supply_low` high, it can first assert on the (LOCK_CYCLES+1)-th edge.
- R10: If `supply_low` is asserted again during the lockout, the full LOCK_CYCLES count restarts from its new falling edge.
- R11: All outputs are registered with one clock of latency. A synchronous reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Processor address bus |
| vma | input | 1 | Valid memory address strobe |
| phi2 | input | 1 | Phase-2 clock qualifier |
| rw | input | 1 | 1 = read, 0 = write |
| wr_timing | input | 1 | Clock-derived write timing gate |
| cal_mode | input | 1 | Calibration mode: unlocks the whole calibration RAM |
| supply_low | input | 1 | Supply-low indication from the supply monitor |
| rom_cs | output | 1 | Program ROM select |
| io_cs | output | 1 | Slow I/O window select |
| nvram_cs | output | 1 | Battery-backed calibration RAM select |
| sram_cs | output | 1 | Scratch RAM select |
| wr_stb | output | 1 | Gated write strobe |

## Verification
The hardest situation to reach is the lockout boundary. The calibration RAM select must return on exactly the (LOCK_CYCLES+1)-th edge, and that count must restart when `supply_low` pulses again partway through. The bench holds a calibration-RAM read address steady, releases the supply-low input, and counts edges until `nvram_cs` rises. It then repeats the count with a one-cycle re-assertion placed ten cycles into the lockout. Overlapping mirrors (F800, B000) and blocked versus permitted calibration writes are driven directly through the scoreboard.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  // Region index doubles as priority rank: lower index wins.
  typedef enum logic [1:0] {
    RG_ROM  = 2'd0,
    RG_IO   = 2'd1,
    RG_NV   = 2'd2,
    RG_SRAM = 2'd3
  } region_e;

  localparam int NUM_REGIONS = 4;
endpackage

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SRAM_SPAN_W = 10
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   qual,
  input  logic                   nv_lock,
  output logic [NUM_REGIONS-1:0] grant
);
  localparam int B15 = ADDR_W - 1;
  localparam int B14 = ADDR_W - 2;
  localparam int B13 = ADDR_W - 3;
  localparam int B12 = ADDR_W - 4;
  localparam int B11 = ADDR_W - 5;

  logic [NUM_REGIONS-1:0] hit;
  logic [NUM_REGIONS-1:0] taken;

  always_comb begin
    hit          = '0;
    hit[RG_ROM]  = qual & addr[B15] & addr[B13] & addr[B12];
    hit[RG_IO]   = qual & addr[B15] & addr[B14] & addr[B11];
    hit[RG_NV]   = qual & addr[B15] & ~addr[B14] & addr[B12] & ~nv_lock;
    hit[RG_SRAM] = qual & (addr[B15:SRAM_SPAN_W] == '0);
  end

  // Fixed-priority resolve, one stage per region.
  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_prio
    if (i == 0) begin : g_first
      assign grant[i] = hit[i];
      assign taken[i] = hit[i];
    end else begin : g_rest
      assign grant[i] = hit[i] & ~taken[i-1];
      assign taken[i] = taken[i-1] | hit[i];
    end
  end
endmodule

// File: rtl/mm_lockout.sv
module mm_lockout #(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (supply_low) begin
      remain <= LOAD;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign locked = supply_low | (remain != '0);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    remain <= LOAD);

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> (remain == LOAD));
endmodule

// File: rtl/mm_write_gate.sv
module mm_write_gate
  import memmap_pkg::*;
(
  input  logic [NUM_REGIONS-1:0] grant,
  input  logic                   rw,
  input  logic                   wr_timing,
  input  logic                   cal_mode,
  input  logic [1:0]             zero_bits,
  output logic                   strobe
);
  logic nv_ok;
  logic target_ok;

  always_comb begin
    nv_ok     = cal_mode | (&zero_bits);
    target_ok = grant[RG_SRAM] | grant[RG_IO] | (grant[RG_NV] & nv_ok);
    strobe    = ~rw & wr_timing & target_ok;
  end
endmodule

// File: rtl/memmap_decode.sv
module memmap_decode
  import memmap_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SRAM_SPAN_W = 10,
  parameter int ZERO_HI     = 7,
  parameter int LOCK_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vma,
  input  logic              phi2,
  input  logic              rw,
  input  logic              wr_timing,
  input  logic              cal_mode,
  input  logic              supply_low,
  output logic              rom_cs,
  output logic              io_cs,
  output logic              nvram_cs,
  output logic              sram_cs,
  output logic              wr_stb
);
  localparam int ZERO_LO = ZERO_HI - 1;

  logic                   qual;
  logic                   nv_lock;
  logic [NUM_REGIONS-1:0] grant;
  logic                   strobe_d;
  logic [NUM_REGIONS-1:0] sel_q;
  logic                   wr_q;

  assign qual = vma & phi2;

  mm_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .supply_low (supply_low),
    .locked     (nv_lock)
  );

  mm_region_decode #(.ADDR_W(ADDR_W), .SRAM_SPAN_W(SRAM_SPAN_W)) u_dec (
    .addr    (addr),
    .qual    (qual),
    .nv_lock (nv_lock),
    .grant   (grant)
  );

  mm_write_gate u_wg (
    .grant     (grant),
    .rw        (rw),
    .wr_timing (wr_timing),
    .cal_mode  (cal_mode),
    .zero_bits (addr[ZERO_HI:ZERO_LO]),
    .strobe    (strobe_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      sel_q <= grant;
      wr_q  <= strobe_d;
    end
  end

  assign rom_cs   = sel_q[RG_ROM];
  assign io_cs    = sel_q[RG_IO];
  assign nvram_cs = sel_q[RG_NV];
  assign sram_cs  = sel_q[RG_SRAM];
  assign wr_stb   = wr_q;

  assert_one_select_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, io_cs, nvram_cs, sram_cs}));

  assert_qualified_R6: assert property (@(posedge clk) disable iff (rst)
    (rom_cs || io_cs || nvram_cs || sram_cs || wr_stb) |-> $past(vma && phi2));

  assert_no_rom_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (!rom_cs && (io_cs || nvram_cs || sram_cs)));

  assert_nv_permit_R8: assert property (@(posedge clk) disable iff (rst)
    (nvram_cs && wr_stb) |-> $past(cal_mode || (addr[ZERO_HI] && addr[ZERO_LO])));

  assert_lock_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    $past(supply_low) |-> !nvram_cs);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!rom_cs && !io_cs && !nvram_cs && !sram_cs && !wr_stb));
endmodule

// File: tb/memmap_decode_bench.sv
module memmap_decode_bench;
  localparam int PERIOD = 10;
  localparam int LOCK   = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        vma = 1'b0, phi2 = 1'b0, rw = 1'b1, wr_timing = 1'b0;
  logic        cal_mode = 1'b0, supply_low = 1'b0;
  logic        rom_cs, io_cs, nvram_cs, sram_cs, wr_stb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  memmap_decode #(.LOCK_CYCLES(LOCK)) u_memmap_decode (
    .clk(clk), .rst(rst), .addr(addr), .vma(vma), .phi2(phi2), .rw(rw),
    .wr_timing(wr_timing), .cal_mode(cal_mode), .supply_low(supply_low),
    .rom_cs(rom_cs), .io_cs(io_cs), .nvram_cs(nvram_cs), .sram_cs(sram_cs),
    .wr_stb(wr_stb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected {rom,io,nv,sram,wr} from the address map requirements.
  function automatic logic [4:0] model(input logic [15:0] a, input logic v, input logic p,
                                       input logic r, input logic wt, input logic cal,
                                       input logic lk);
    logic q, rom, io, nv, sr, wr;
    q   = v & p;
    rom = q & (a[15:12] == 4'hF || a[15:12] == 4'hB);
    io  = q & a[15] & a[14] & a[11] & !rom;
    nv  = q & (a[15:12] == 4'h9) & !lk;
    sr  = q & (a < 16'h0400);
    wr  = !r & wt & (sr | io | (nv & (cal | (a[7:6] == 2'b11))));
    return {rom, io, nv, sr, wr};
  endfunction

  task automatic drive(input logic [15:0] a, input logic v, input logic p, input logic r,
                       input logic wt, input logic cal, input string tag);
    @(negedge clk);
    addr = a; vma = v; phi2 = p; rw = r; wr_timing = wt; cal_mode = cal;
    exp_q.push_back(model(a, v, p, r, wt, cal, supply_low));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        logic [4:0] got;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {rom_cs, io_cs, nvram_cs, sram_cs, wr_stb};
        check(got == e, t, got, e);
      end
    end
  end

  task automatic count_release(input string tag);
    int first;
    first = 0;
    for (int i = 1; i <= LOCK + 5; i++) begin
      @(posedge clk);
      #1;
      if (first == 0 && nvram_cs) first = i;
    end
    check(first == LOCK + 1, tag, first, LOCK + 1);
  endtask

  initial begin : stim
    repeat (3) @(negedge clk);
    check({rom_cs, io_cs, nvram_cs, sram_cs, wr_stb} == 5'b0, "R11 reset clear",
          {rom_cs, io_cs, nvram_cs, sram_cs, wr_stb}, 0);
    rst = 1'b0;

    drive(16'hF123, 1, 1, 1, 0, 0, "R1 rom F000 page");
    drive(16'hB456, 1, 1, 1, 0, 0, "R1 rom mirror B000 (R5 over nvram)");
    drive(16'h0042, 1, 1, 1, 0, 0, "R2 sram base");
    drive(16'h0142, 1, 1, 0, 1, 0, "R2 sram mirror write");
    drive(16'h03FF, 1, 1, 1, 0, 0, "R2 sram top mirror");
    drive(16'h0400, 1, 1, 1, 0, 0, "R2 unmapped above sram");
    drive(16'h9000, 1, 1, 1, 0, 0, "R3 nvram read");
    drive(16'h9A3C, 1, 1, 0, 1, 0, "R8 nvram blocked write");
    drive(16'h90C4, 1, 1, 0, 1, 0, "R8 nvram zero area write");
    drive(16'h9A3C, 1, 1, 0, 1, 1, "R8 nvram cal write");
    drive(16'h9A3C, 1, 1, 1, 1, 0, "R8 nvram read of protected");
    drive(16'hC800, 1, 1, 0, 1, 0, "R4 io write");
    drive(16'hE9AB, 1, 1, 1, 0, 0, "R4 io mirror");
    drive(16'hF800, 1, 1, 0, 1, 0, "R5 rom over io, R7 no rom write");
    drive(16'h0010, 0, 1, 0, 1, 0, "R6 vma low");
    drive(16'hC800, 1, 0, 0, 1, 0, "R6 phi2 low");
    drive(16'h0010, 1, 1, 0, 0, 0, "R7 timing gate low");
    drive(16'h4100, 1, 1, 0, 1, 0, "R7 unmapped write");
    repeat (3) @(negedge clk);

    // Lockout: hold a calibration-RAM read.
    addr = 16'h9000; vma = 1; phi2 = 1; rw = 1; wr_timing = 0; cal_mode = 0;
    supply_low = 1'b1;
    repeat (3) @(negedge clk);
    check(nvram_cs == 1'b0, "R9 blocked while supply low", nvram_cs, 0);
    supply_low = 1'b0;
    count_release("R9 release edge");

    @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    repeat (10) @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    count_release("R10 restart on reassert");

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : watchdog
    #(PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule